// File: doc/BRIEF.md
# Integer/Fractional Loop Feedback Divider

This block divides a fast input clock by a programmable ratio and produces the divided clock that a phase comparator would compare against a reference. In integer mode every output period is exactly N input cycles, with the high phase taking the larger half. In fractional mode a 16-bit phase accumulator stretches chosen periods to N+1 cycles. The average ratio is then N + F/65536.

The accumulator is stepped once per output period, at the rising edge of the divided clock. Its overflow decides the length of the period that has just begun, and that decision is shown on a separate carry output so that a checker can follow the modulus sequence. A range check runs all the time. It flags an integer part that the selected mode cannot use. While that flag is up, the divider is parked in its cleared state with the output low.

Top module: `loop_fbdiv`

## Requirements
- R1: While the asynchronous active-low reset is asserted, div_clk_o and carry_o are low and the counter and accumulator are cleared. The first fractional addition after reset therefore starts from zero.
- R2: In integer mode (mode_i = 0), every period of div_clk_o between rising edges lasts exactly ratio_i input cycles, and frac_i has no effect.
- R3: In each output period of P cycles, div_clk_o is high for (P+1)/2 cycles, rounded down, and low for the rest. This gives an exact 50% duty for even P.
- R4: In integer mode the accumulator is held at zero and carry_o stays low from the cycle after integer mode is seen.
- R5: In integer mode, range_err_o is low for ratio_i from 2 to 66 inclusive and high for any other value.
- R6: In fractional mode (mode_i = 1), range_err_o is low for ratio_i from 8 to 66 inclusive and high for any other value. For example, 5 is legal in integer mode but not in fractional mode.
- R7: In the cycle after range_err_o is seen high, div_clk_o is low and the divider is cleared. When the setting becomes legal again, division resumes.
- R8: In fractional mode, frac_i is added to the 16-bit accumulator at each rising edge of div_clk_o. carry_o is high for the period that starts there exactly when that addition overflowed, and the period lasts ratio_i + carry_o cycles.
- R9: In fractional mode, the cycles in 2^k consecutive periods counted from reset sum to N*2^k + F/2^(16-k) when the low 16-k bits of F are zero. For k = 16 this is N*65536 + F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects integer mode, 1 selects fractional mode |
| ratio_i | input | 7 | Integer part N of the division ratio |
| frac_i | input | 16 | Fractional part F, weighted 1/65536 |
| div_clk_o | output | 1 | Divided clock, registered |
| carry_o | output | 1 | High during a period stretched to N+1 |
| range_err_o | output | 1 | Integer part illegal for the selected mode |

## Verification
The properties assume that mode_i, ratio_i and frac_i are synchronous to clk_i. The carry property additionally assumes that the mode held steady in the cycle before a carry change, and it does not apply right after an error, because the error clears the carry. The stimulus changes the configuration only on the falling clock edge. After each table entry it pulses reset, so every measurement starts from a zero accumulator. A mid-run switch to an illegal ratio checks that recovery runs through the cleared state rather than through a stale count.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    typedef enum logic {
        FB_INT  = 1'b0,
        FB_FRAC = 1'b1
    } fb_mode_e;

endpackage

// File: rtl/fbdiv_range.sv
module fbdiv_range #(
    parameter int RATIO_W = 7,
    parameter int INT_LO  = 2,
    parameter int INT_HI  = 66,
    parameter int FRAC_LO = 8,
    parameter int FRAC_HI = 66
) (
    input  logic               frac_on_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               bad_o
);

    localparam logic [RATIO_W-1:0] ILO = RATIO_W'(INT_LO);
    localparam logic [RATIO_W-1:0] IHI = RATIO_W'(INT_HI);
    localparam logic [RATIO_W-1:0] FLO = RATIO_W'(FRAC_LO);
    localparam logic [RATIO_W-1:0] FHI = RATIO_W'(FRAC_HI);

    logic int_ok;
    logic frac_ok;

    always_comb begin
        int_ok  = (ratio_i >= ILO) && (ratio_i <= IHI);
        frac_ok = (ratio_i >= FLO) && (ratio_i <= FHI);
        bad_o   = frac_on_i ? !frac_ok : !int_ok;
    end

endmodule

// File: rtl/fbdiv_sigma.sv
module fbdiv_sigma #(
    parameter int FRAC_W = 16
) (
    input  logic [FRAC_W-1:0] acc_i,
    input  logic [FRAC_W-1:0] step_i,
    output logic [FRAC_W-1:0] acc_o,
    output logic              ovf_o
);

    logic [FRAC_W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, acc_i} + {1'b0, step_i};
        acc_o    = wide_sum[FRAC_W-1:0];
        ovf_o    = wide_sum[FRAC_W];
    end

endmodule

// File: rtl/fbdiv_phase.sv
module fbdiv_phase #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             last_o,
    output logic [CNT_W-1:0] cnt_nx_o,
    output logic             out_nx_o
);

    logic [CNT_W-1:0] half_up;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        half_up  = (period_i >> 1) + CNT_W'(period_i[0]);
        cnt_inc  = cnt_i + CNT_W'(1);
        // ">=" also catches a count left beyond a freshly shortened ratio
        last_o   = (cnt_i >= (period_i - CNT_W'(1)));
        cnt_nx_o = last_o ? '0 : cnt_inc;
        out_nx_o = last_o ? 1'b1 : (cnt_inc < half_up);
    end

endmodule

// File: rtl/loop_fbdiv.sv
module loop_fbdiv #(
    parameter int RATIO_W = 7,
    parameter int FRAC_W  = 16,
    parameter int INT_LO  = 2,
    parameter int INT_HI  = 66,
    parameter int FRAC_LO = 8,
    parameter int FRAC_HI = 66
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               mode_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [FRAC_W-1:0]  frac_i,
    output logic               div_clk_o,
    output logic               carry_o,
    output logic               range_err_o
);

    import fbdiv_pkg::*;

    localparam int CNT_W = RATIO_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              plus;
        logic              out;
    } fb_state_t;

    fb_state_t state_d, state_q;

    logic              frac_on;
    logic              bad;
    logic [CNT_W-1:0]  period;
    logic              wrap;
    logic [CNT_W-1:0]  cnt_nx;
    logic              out_nx;
    logic [FRAC_W-1:0] acc_nx;
    logic              ovf;

    assign frac_on = (fb_mode_e'(mode_i) == FB_FRAC);
    assign period  = CNT_W'(ratio_i) + CNT_W'(frac_on & state_q.plus);

    fbdiv_range #(
        .RATIO_W (RATIO_W),
        .INT_LO  (INT_LO),
        .INT_HI  (INT_HI),
        .FRAC_LO (FRAC_LO),
        .FRAC_HI (FRAC_HI)
    ) u_range (
        .frac_on_i (frac_on),
        .ratio_i   (ratio_i),
        .bad_o     (bad)
    );

    fbdiv_sigma #(
        .FRAC_W (FRAC_W)
    ) u_sigma (
        .acc_i  (state_q.acc),
        .step_i (frac_i),
        .acc_o  (acc_nx),
        .ovf_o  (ovf)
    );

    fbdiv_phase #(
        .CNT_W (CNT_W)
    ) u_phase (
        .period_i (period),
        .cnt_i    (state_q.cnt),
        .last_o   (wrap),
        .cnt_nx_o (cnt_nx),
        .out_nx_o (out_nx)
    );

    always_comb begin
        state_d = state_q;
        if (bad) begin
            state_d = '0;
        end else begin
            state_d.cnt = cnt_nx;
            state_d.out = out_nx;
            if (!frac_on) begin
                state_d.acc  = '0;
                state_d.plus = 1'b0;
            end else if (wrap) begin
                state_d.acc  = acc_nx;
                state_d.plus = ovf;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign div_clk_o   = state_q.out;
    assign carry_o     = state_q.plus;
    assign range_err_o = bad;

endmodule

// File: rtl/loop_fbdiv_chk.sv
module loop_fbdiv_chk #(
    parameter int RATIO_W = 7,
    parameter int INT_LO  = 2,
    parameter int INT_HI  = 66,
    parameter int FRAC_LO = 8,
    parameter int FRAC_HI = 66
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               mode_i,
    input logic [RATIO_W-1:0] ratio_i,
    input logic               div_clk_o,
    input logic               carry_o,
    input logic               range_err_o
);

    localparam logic [RATIO_W-1:0] ILO = RATIO_W'(INT_LO);
    localparam logic [RATIO_W-1:0] IHI = RATIO_W'(INT_HI);
    localparam logic [RATIO_W-1:0] FLO = RATIO_W'(FRAC_LO);
    localparam logic [RATIO_W-1:0] FHI = RATIO_W'(FRAC_HI);

    p_reset_low_r1: assert property (@(posedge clk_i)
        !rst_ni |-> (!div_clk_o && !carry_o));

    p_int_no_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!mode_i) |-> !carry_o);

    p_int_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_i |-> (range_err_o == ((ratio_i < ILO) || (ratio_i > IHI))));

    p_frac_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i |-> (range_err_o == ((ratio_i < FLO) || (ratio_i > FHI))));

    p_err_parks_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        range_err_o |=> !div_clk_o);

    p_carry_at_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mode_i) && !$past(range_err_o) && !$stable(carry_o)) |-> $rose(div_clk_o));

endmodule

bind loop_fbdiv loop_fbdiv_chk #(
    .RATIO_W (RATIO_W),
    .INT_LO  (INT_LO),
    .INT_HI  (INT_HI),
    .FRAC_LO (FRAC_LO),
    .FRAC_HI (FRAC_HI)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .ratio_i     (ratio_i),
    .div_clk_o   (div_clk_o),
    .carry_o     (carry_o),
    .range_err_o (range_err_o)
);

// File: tb/loop_fbdiv_tb.sv
`timescale 1ns/1ps
module loop_fbdiv_tb;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        mode_i = 1'b0;
    logic [6:0]  ratio_i = 7'd4;
    logic [15:0] frac_i = 16'h0;
    logic        div_clk_o;
    logic        carry_o;
    logic        range_err_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk_i = ~clk_i;

    loop_fbdiv u_dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_i      (mode_i),
        .ratio_i     (ratio_i),
        .frac_i      (frac_i),
        .div_clk_o   (div_clk_o),
        .carry_o     (carry_o),
        .range_err_o (range_err_o)
    );

    // {mode, ratio, frac, expect_err, periods, expected cycle sum}
    localparam int NV = 17;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 7'd2,  16'h0000, 1'b0, 5'd4, 12'd8},
        {1'b0, 7'd3,  16'h0000, 1'b0, 5'd4, 12'd12},
        {1'b0, 7'd66, 16'h0000, 1'b0, 5'd2, 12'd132},
        {1'b0, 7'd17, 16'h0000, 1'b0, 5'd3, 12'd51},
        {1'b0, 7'd8,  16'hFFFF, 1'b0, 5'd4, 12'd32},
        {1'b0, 7'd5,  16'h1234, 1'b0, 5'd3, 12'd15},
        {1'b0, 7'd1,  16'h0000, 1'b1, 5'd0, 12'd0},
        {1'b0, 7'd67, 16'h0000, 1'b1, 5'd0, 12'd0},
        {1'b0, 7'd0,  16'h0000, 1'b1, 5'd0, 12'd0},
        {1'b1, 7'd8,  16'h0000, 1'b0, 5'd4, 12'd32},
        {1'b1, 7'd8,  16'h8000, 1'b0, 5'd2, 12'd17},
        {1'b1, 7'd10, 16'hC000, 1'b0, 5'd4, 12'd43},
        {1'b1, 7'd66, 16'h2000, 1'b0, 5'd8, 12'd529},
        {1'b1, 7'd20, 16'h4000, 1'b0, 5'd4, 12'd81},
        {1'b1, 7'd9,  16'hFFFF, 1'b0, 5'd8, 12'd79},
        {1'b1, 7'd5,  16'h0000, 1'b1, 5'd0, 12'd0},
        {1'b1, 7'd67, 16'h4000, 1'b1, 5'd0, 12'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    task automatic pulse_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    // Measures n whole periods starting at the next rising edge of div_clk_o.
    task automatic measure(input int n, input int nr, input bit fm, input bit fzero,
                           output int total);
        logic last;
        total = 0;
        last  = 1'b1;
        do begin
            @(negedge clk_i);
            if (div_clk_o && !last) break;
            last = div_clk_o;
        end while (1);
        for (int k = 0; k < n; k++) begin
            int  len;
            int  hi;
            int  expp;
            bit  cy;
            cy   = carry_o;
            len  = 1;
            hi   = 1;
            last = 1'b1;
            do begin
                @(negedge clk_i);
                if (div_clk_o && !last) break;
                len++;
                if (div_clk_o) hi++;
                last = div_clk_o;
            end while (1);
            expp = nr + (fm ? int'(cy) : 0);
            if (fm) check(len == expp, "R8 period follows carry", len, expp);
            else    check(len == nr, "R2 integer period", len, nr);
            check(hi == (expp + 1) / 2, "R3 high phase", hi, (expp + 1) / 2);
            if (!fm)   check(cy == 1'b0, "R4 carry low in integer mode", cy, 0);
            if (fzero) check(cy == 1'b0, "R8 zero fraction never stretches", cy, 0);
            total += len;
        end
    endtask

    initial begin
        #(8ns * 150000);
        n_fail++;
        $display("FAIL watchdog expired, run did not complete");
        summary();
        $finish;
    end

    initial begin
        int tot;
        // R1: state during reset
        repeat (3) @(negedge clk_i);
        check(div_clk_o == 1'b0, "R1 div low in reset", div_clk_o, 0);
        check(carry_o == 1'b0, "R1 carry low in reset", carry_o, 0);
        rst_ni = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [41:0] e;
            e = VEC[v];
            @(negedge clk_i);
            mode_i  = e[41];
            ratio_i = e[40:34];
            frac_i  = e[33:18];
            pulse_reset();
            #1;
            if (e[17]) begin
                check(range_err_o == 1'b1, mode_i ? "R6 frac range flag" : "R5 int range flag",
                      range_err_o, 1);
                begin
                    bit stayed_low;
                    stayed_low = 1'b1;
                    repeat (12) begin
                        @(negedge clk_i);
                        if (div_clk_o) stayed_low = 1'b0;
                    end
                    check(stayed_low, "R7 output parked low", stayed_low, 1);
                end
            end else begin
                check(range_err_o == 1'b0, mode_i ? "R6 frac legal" : "R5 int legal",
                      range_err_o, 0);
                measure(int'(e[16:12]), int'(e[40:34]), e[41], e[41] && (e[33:18] == 16'h0), tot);
                check(tot == int'(e[11:0]), mode_i ? "R9 cycle sum" : "R2 cycle sum",
                      tot, int'(e[11:0]));
            end
        end

        // R1: reset mid-run while a stretched period may be in progress
        @(negedge clk_i);
        mode_i = 1'b1; ratio_i = 7'd10; frac_i = 16'hC000;
        pulse_reset();
        repeat (37) @(negedge clk_i);
        rst_ni = 1'b0;
        #1;
        check(div_clk_o == 1'b0, "R1 async reset clears div", div_clk_o, 0);
        check(carry_o == 1'b0, "R1 async reset clears carry", carry_o, 0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        measure(4, 10, 1'b1, 1'b0, tot);
        check(tot == 43, "R1 accumulator restarts from zero", tot, 43);

        // R7: illegal ratio while running, then recovery
        @(negedge clk_i);
        mode_i = 1'b0; ratio_i = 7'd6; frac_i = 16'h0;
        pulse_reset();
        repeat (4) @(negedge clk_i);
        ratio_i = 7'd70;
        #1;
        check(range_err_o == 1'b1, "R5 ratio 70 flagged", range_err_o, 1);
        begin
            bit stayed_low;
            stayed_low = 1'b1;
            repeat (10) begin
                @(negedge clk_i);
                if (div_clk_o) stayed_low = 1'b0;
            end
            check(stayed_low, "R7 low while in error", stayed_low, 1);
        end
        ratio_i = 7'd6;
        measure(2, 6, 1'b0, 1'b0, tot);
        check(tot == 12, "R7 resumes after error", tot, 12);

        // R6: the same integer part is legal in one mode and illegal in the other
        @(negedge clk_i);
        mode_i = 1'b0; ratio_i = 7'd5;
        #1;
        check(range_err_o == 1'b0, "R5 ratio 5 legal in integer mode", range_err_o, 0);
        @(negedge clk_i);
        mode_i = 1'b1;
        #1;
        check(range_err_o == 1'b1, "R6 ratio 5 illegal in fractional mode", range_err_o, 1);

        summary();
        $finish;
    end

endmodule